// File: doc/BRIEF.md
# Capacitive Raw-Count Sample Filter

This block conditions the stream of raw counts from a capacitive touch front end before touch detection runs on them. The scanner visits each sensor in turn. For every completed scan it delivers one 16-bit raw count, the index of the sensor that was scanned, and a flag that is set when the serial host bus was busy during the scan. Host bus traffic during a scan can couple noise into the measurement. The filter can therefore throw such samples away.

Accepted samples either pass straight through or are averaged in blocks of 2, 4, 8 or 16. Each sensor has its own block, so the averaging of one sensor never mixes with another. Every result leaves on a one-cycle valid strobe, together with its sensor index. The block also holds one baseline per sensor. Each baseline is captured from the first filtered value of its sensor after reset, or after software writes the self-clearing baseline-reset command.

An 8-bit control register sets the behaviour. It holds the drop enable, the averaging enable, the averaging order and the baseline-reset command.

Top module: `cap_sample_filter`

## Requirements
- R1: After reset the control register reads 8'h10, which means averaging is on with order 0 and drop is off. `flt_valid` is 0 and every baseline is 0.
- R2: A control write stores bit 5 (drop enable), bit 4 (averaging enable) and bits 1:0 (averaging order). Bits 7, 6, 3 and 2 always read back as 0.
- R3: With averaging disabled, an accepted sample produces `flt_valid` in the next cycle. In that cycle `flt_count` and `flt_sensor` equal the sample's count and index.
- R4: With averaging enabled, the block size N is 2 for order code 00, 4 for 01, 8 for 10 and 16 for 11. On the Nth accepted sample of a sensor, the next cycle carries `flt_valid` with floor(sum of the N counts / N). The sensor's block then restarts empty. Accepted samples that do not complete a block produce no `flt_valid`.
- R5: Block accumulation is kept separately per sensor index, so interleaved sensors do not disturb each other.
- R6: With the drop enable at 1, a sample whose `smp_bus_busy` is 1 is discarded. It produces no `flt_valid` and does not count toward a block.
- R7: With the drop enable at 0, samples with `smp_bus_busy` at 1 are treated like any other sample.
- R8: A control write that changes the averaging enable or the averaging order empties every sensor's partial block.
- R9: After reset, each sensor's baseline loads from that sensor's first filtered value, one cycle after its `flt_valid`. Later filtered values leave the baseline unchanged.
- R10: Writing 1 to bit 7 arms a reload of all baselines in the same clock. Each sensor's baseline then loads from its next filtered value, and bit 7 reads back as 0.
- R11: Sixteen samples of 16'hFFFF at order 11 average to 16'hFFFF, with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_data | input | 8 | Control register write data |
| cfg_rd_data | output | 8 | Control register read value |
| smp_valid | input | 1 | A raw sample is presented this cycle |
| smp_sensor | input | IDX_W | Sensor index of the sample |
| smp_count | input | RAW_W | Raw count of the sample |
| smp_bus_busy | input | 1 | Host bus was active during this scan |
| flt_valid | output | 1 | Filtered value strobe |
| flt_sensor | output | IDX_W | Sensor index of the filtered value |
| flt_count | output | RAW_W | Filtered count |
| baseline | output | NUM_SENSORS*RAW_W | Baselines, sensor 0 in the low bits |

## Verification
Directed sequences come first:
- A lone pass-through sample on each sensor separates baseline capture from baseline hold.
- Partial blocks that are followed by an order change show whether the accumulators are emptied.
- Sixteen full-scale samples expose any truncation of the accumulator.
- Busy-flagged samples are applied with the drop enable at 1 and then at 0, which separates discard from acceptance.

A seeded random mix of sensor indices, counts, busy flags and control writes then interleaves the sensors. It shows that the block state of one sensor never leaks into another, and that the baseline-reset command reloads only on each sensor's next result.

// File: rtl/capf_pkg.sv
package capf_pkg;
  localparam int ORD_W     = 2;
  localparam int MAX_SHIFT = 4;
  localparam int CNT_W     = MAX_SHIFT;
  localparam int CFG_W     = 8;
  localparam int BIT_BRST  = 7;
  localparam int BIT_DROP  = 5;
  localparam int BIT_AVG   = 4;
  localparam logic [CFG_W-1:0] CFG_MASK  = 8'h33;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h10;

  // index of the last sample in a block: N-1 where N = 2^(order+1)
  function automatic logic [CNT_W-1:0] block_last(input logic [ORD_W-1:0] ord);
    case (ord)
      2'd0:    block_last = 4'd1;
      2'd1:    block_last = 4'd3;
      2'd2:    block_last = 4'd7;
      default: block_last = 4'd15;
    endcase
  endfunction

  function automatic logic [2:0] block_shift(input logic [ORD_W-1:0] ord);
    block_shift = 3'(ord) + 3'd1;
  endfunction
endpackage

// File: rtl/capf_cfg_reg.sv
module capf_cfg_reg
  import capf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] rd_data,
  output logic             drop_en,
  output logic             avg_en,
  output logic [ORD_W-1:0] avg_order,
  output logic             base_rst_cmd,
  output logic             acc_clear
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else if (wr_en) cfg_q <= wr_data & CFG_MASK;
  end

  assign rd_data      = cfg_q;
  assign drop_en      = cfg_q[BIT_DROP];
  assign avg_en       = cfg_q[BIT_AVG];
  assign avg_order    = cfg_q[ORD_W-1:0];
  assign base_rst_cmd = wr_en && wr_data[BIT_BRST];
  assign acc_clear    = wr_en && ((wr_data[BIT_AVG] != cfg_q[BIT_AVG]) ||
                                  (wr_data[ORD_W-1:0] != cfg_q[ORD_W-1:0]));
endmodule

// File: rtl/capf_avg_bank.sv
module capf_avg_bank
  import capf_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int RAW_W       = 16,
  parameter int IDX_W       = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             avg_en,
  input  logic [ORD_W-1:0] avg_order,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_sensor,
  input  logic [RAW_W-1:0] in_count,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_sensor,
  output logic [RAW_W-1:0] out_count
);
  localparam int ACC_W = RAW_W + MAX_SHIFT;
  localparam int DEPTH = 1 << IDX_W;

  logic [ACC_W-1:0] acc_mem [DEPTH];
  logic [CNT_W-1:0] cnt_mem [DEPTH];

  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] shifted;
  logic             last;

  always_comb begin
    sum     = acc_mem[in_sensor] + ACC_W'(in_count);
    shifted = sum >> block_shift(avg_order);
    last    = (cnt_mem[in_sensor] == block_last(avg_order));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sensor <= '0;
      out_count  <= '0;
    end else begin
      out_valid  <= in_valid && (!avg_en || last);
      out_sensor <= in_sensor;
      out_count  <= avg_en ? shifted[RAW_W-1:0] : in_count;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int i = 0; i < DEPTH; i++) begin
        acc_mem[i] <= '0;
        cnt_mem[i] <= '0;
      end
    end else if (in_valid && avg_en) begin
      if (last) begin
        acc_mem[in_sensor] <= '0;
        cnt_mem[in_sensor] <= '0;
      end else begin
        acc_mem[in_sensor] <= sum;
        cnt_mem[in_sensor] <= cnt_mem[in_sensor] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/capf_baseline_bank.sv
module capf_baseline_bank #(
  parameter int NUM_SENSORS = 2,
  parameter int RAW_W       = 16,
  parameter int IDX_W       = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reload_cmd,
  input  logic                         flt_valid,
  input  logic [IDX_W-1:0]             flt_sensor,
  input  logic [RAW_W-1:0]             flt_count,
  output logic [NUM_SENSORS*RAW_W-1:0] baseline
);
  for (genvar g = 0; g < NUM_SENSORS; g++) begin : g_sensor
    logic [RAW_W-1:0] base_q;
    logic             armed_q;
    logic             hit;

    assign hit = flt_valid && (flt_sensor == IDX_W'(g)) && (armed_q || reload_cmd);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q  <= '0;
        armed_q <= 1'b1;
      end else if (hit) begin
        base_q  <= flt_count;
        armed_q <= 1'b0;
      end else if (reload_cmd) begin
        armed_q <= 1'b1;
      end
    end

    assign baseline[g*RAW_W +: RAW_W] = base_q;
  end
endmodule

// File: rtl/cap_sample_filter.sv
module cap_sample_filter
  import capf_pkg::*;
#(
  parameter int NUM_SENSORS = 2,
  parameter int RAW_W       = 16,
  parameter int IDX_W       = (NUM_SENSORS > 1) ? $clog2(NUM_SENSORS) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_wr_en,
  input  logic [7:0]                   cfg_wr_data,
  output logic [7:0]                   cfg_rd_data,
  input  logic                         smp_valid,
  input  logic [IDX_W-1:0]             smp_sensor,
  input  logic [RAW_W-1:0]             smp_count,
  input  logic                         smp_bus_busy,
  output logic                         flt_valid,
  output logic [IDX_W-1:0]             flt_sensor,
  output logic [RAW_W-1:0]             flt_count,
  output logic [NUM_SENSORS*RAW_W-1:0] baseline
);
  logic             drop_en, avg_en, base_rst_cmd, acc_clear, accepted;
  logic [ORD_W-1:0] avg_order;

  capf_cfg_reg u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (cfg_wr_en),
    .wr_data      (cfg_wr_data),
    .rd_data      (cfg_rd_data),
    .drop_en      (drop_en),
    .avg_en       (avg_en),
    .avg_order    (avg_order),
    .base_rst_cmd (base_rst_cmd),
    .acc_clear    (acc_clear)
  );

  assign accepted = smp_valid && !(drop_en && smp_bus_busy);

  capf_avg_bank #(
    .NUM_SENSORS (NUM_SENSORS),
    .RAW_W       (RAW_W),
    .IDX_W       (IDX_W)
  ) u_avg (
    .clk        (clk),
    .rst        (rst),
    .clear      (acc_clear),
    .avg_en     (avg_en),
    .avg_order  (avg_order),
    .in_valid   (accepted),
    .in_sensor  (smp_sensor),
    .in_count   (smp_count),
    .out_valid  (flt_valid),
    .out_sensor (flt_sensor),
    .out_count  (flt_count)
  );

  capf_baseline_bank #(
    .NUM_SENSORS (NUM_SENSORS),
    .RAW_W       (RAW_W),
    .IDX_W       (IDX_W)
  ) u_base (
    .clk        (clk),
    .rst        (rst),
    .reload_cmd (base_rst_cmd),
    .flt_valid  (flt_valid),
    .flt_sensor (flt_sensor),
    .flt_count  (flt_count),
    .baseline   (baseline)
  );
endmodule

// File: rtl/cap_sample_filter_chk.sv
module cap_sample_filter_chk #(
  parameter int NUM_SENSORS = 2,
  parameter int RAW_W       = 16,
  parameter int IDX_W       = 1
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         cfg_wr_en,
  input logic [7:0]                   cfg_wr_data,
  input logic [7:0]                   cfg_rd_data,
  input logic                         smp_valid,
  input logic [IDX_W-1:0]             smp_sensor,
  input logic [RAW_W-1:0]             smp_count,
  input logic                         smp_bus_busy,
  input logic                         flt_valid,
  input logic [IDX_W-1:0]             flt_sensor,
  input logic [RAW_W-1:0]             flt_count,
  input logic [NUM_SENSORS*RAW_W-1:0] baseline
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!flt_valid && cfg_rd_data == 8'h10 && baseline == '0));

  p_passthrough_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !cfg_rd_data[4] && !(cfg_rd_data[5] && smp_bus_busy))
      |=> (flt_valid && flt_count == $past(smp_count) && flt_sensor == $past(smp_sensor)));

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && !(cfg_rd_data[5] && smp_bus_busy)) |=> !flt_valid);

  p_busy_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_bus_busy && !cfg_rd_data[5] && !cfg_rd_data[4]) |=> flt_valid);

  p_baseline_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !flt_valid |=> $stable(baseline));

  p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && cfg_wr_data[7]) |=> !cfg_rd_data[7]);
endmodule

bind cap_sample_filter cap_sample_filter_chk #(
  .NUM_SENSORS (NUM_SENSORS),
  .RAW_W       (RAW_W),
  .IDX_W       (IDX_W)
) chk_i (.*);

// File: tb/cap_sample_filter_tb_top.sv
module cap_sample_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 2;
  localparam int RW = 16;
  localparam int IW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic [7:0]    cfg_wr_data = '0;
  logic [7:0]    cfg_rd_data;
  logic          smp_valid = 1'b0;
  logic [IW-1:0] smp_sensor = '0;
  logic [RW-1:0] smp_count = '0;
  logic          smp_bus_busy = 1'b0;
  logic          flt_valid;
  logic [IW-1:0] flt_sensor;
  logic [RW-1:0] flt_count;
  logic [NS*RW-1:0] baseline;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_sample_filter #(.NUM_SENSORS(NS), .RAW_W(RW)) dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;

  // reference model state
  bit          m_drop, m_avg;
  int          m_ord;
  longint      m_acc  [NS];
  int          m_cnt  [NS];
  int          m_base [NS];
  bit          m_arm  [NS];

  function automatic int blk_size(int ord);
    return 1 << (ord + 1);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_drop = 0; m_avg = 1; m_ord = 0;
    for (int i = 0; i < NS; i++) begin
      m_acc[i] = 0; m_cnt[i] = 0; m_base[i] = 0; m_arm[i] = 1;
    end
  endtask

  task automatic wr_cfg(logic [7:0] d);
    string tag;
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    if (d[4] != m_avg || int'(d[1:0]) != m_ord)
      for (int i = 0; i < NS; i++) begin m_acc[i] = 0; m_cnt[i] = 0; end  // R8
    m_drop = d[5]; m_avg = d[4]; m_ord = int'(d[1:0]);
    if (d[7]) for (int i = 0; i < NS; i++) m_arm[i] = 1;
    tag = d[7] ? "R10" : "R2";
    chk(cfg_rd_data == (d & 8'h33), tag, "cfg readback", cfg_rd_data, d & 8'h33);
  endtask

  task automatic do_sample(int s, int cnt, bit busy);
    bit    exp_v;
    int    exp_c;
    string tag;
    @(negedge clk);
    smp_valid = 1'b1; smp_sensor = IW'(s); smp_count = RW'(cnt); smp_bus_busy = busy;
    exp_v = 0; exp_c = 0;
    if (m_drop && busy) tag = "R6";
    else begin
      if (m_avg) begin
        tag = "R4";
        m_acc[s] += cnt; m_cnt[s]++;
        if (m_cnt[s] == blk_size(m_ord)) begin
          exp_v = 1; exp_c = int'(m_acc[s] >> (m_ord + 1));
          m_acc[s] = 0; m_cnt[s] = 0;
        end
      end else begin
        tag = busy ? "R7" : "R3";
        exp_v = 1; exp_c = cnt;
      end
      if (exp_v && m_arm[s]) begin m_base[s] = exp_c; m_arm[s] = 0; end
    end
    @(posedge clk);
    @(negedge clk);
    smp_valid = 1'b0; smp_bus_busy = 1'b0;
    chk(flt_valid == exp_v, tag, "flt_valid", flt_valid, exp_v);
    if (exp_v) begin
      chk(flt_count == RW'(exp_c), tag, "flt_count", flt_count, exp_c);
      chk(int'(flt_sensor) == s, "R5", "flt_sensor", flt_sensor, s);
    end
  endtask

  task automatic check_base(string tag);
    @(negedge clk);
    for (int i = 0; i < NS; i++)
      chk(baseline[i*RW +: RW] == RW'(m_base[i]), tag, "baseline",
          baseline[i*RW +: RW], m_base[i]);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk(cfg_rd_data == 8'h10, "R1", "cfg reset", cfg_rd_data, 8'h10);
    chk(flt_valid == 1'b0, "R1", "flt_valid reset", flt_valid, 0);
    chk(baseline == '0, "R1", "baseline reset", baseline, 0);

    // R3 passthrough, R9 first-output baseline capture then hold
    wr_cfg(8'h00);
    do_sample(0, 1234, 0);
    do_sample(1, 77, 0);
    check_base("R9");
    do_sample(0, 999, 0);
    check_base("R9");

    // R2 unused bits read zero (bit 7 also arms a reload)
    wr_cfg(8'hFF);
    wr_cfg(8'h11);
    // R8 partial block then order change
    do_sample(0, 100, 0);
    do_sample(0, 300, 0);
    wr_cfg(8'h10);
    do_sample(0, 10, 0);
    do_sample(0, 21, 0);           // R8: expect (10+21)/2 only
    check_base("R10");

    // R11 full-scale block of 16
    wr_cfg(8'h13);
    for (int i = 0; i < 16; i++) do_sample(1, 16'hFFFF, 0);
    check_base("R11");

    // R6 / R7 bus-busy handling
    wr_cfg(8'h30);
    do_sample(0, 555, 1);
    do_sample(0, 556, 0);
    wr_cfg(8'h00);
    do_sample(1, 4321, 1);

    // R10 reload command
    wr_cfg(8'h80);
    do_sample(1, 42, 0);
    check_base("R10");
    do_sample(0, 43, 0);
    check_base("R10");

    // R5 random interleave
    for (int k = 0; k < 800; k++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) wr_cfg(8'($urandom) & 8'hB3);
      else do_sample($urandom % NS, $urandom % 65536, ($urandom % 4) == 0);
      if (k % 25 == 0) check_base("R5");
    end
    check_base("R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule